// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block fetches one 16-bit word from a small three-wire serial EEPROM that is addressed in 16-bit words. The user side raises `start_i` for one clock with a word address and a width select. The block then drives the memory's select, clock and data-in pins and samples its data-out pin. It pulses `done_o` for one cycle when the word is in `data_o`. Two memory sizes are supported, and the choice is made per request: the smaller part takes a 6-bit word address and the larger part takes an 8-bit one.

Every level on the three outgoing pins is held for `HALF_CYC` system clocks, which sets the serial clock to `HALF_CYC*2` system clocks per period. The sequencer walks the following named states:

- `ST_IDLE` goes to `ST_SELECT` on start.
- `ST_SELECT` raises select.
- `ST_LEAD_HI` and `ST_LEAD_LO` form one leading clock pulse.
- For each command or address bit, `ST_TX_SET` places the bit, then `ST_TX_HI` and `ST_TX_LO` clock it. After the last bit the sequencer goes to `ST_RX_PREP`, which forces data-in low.
- `ST_RX_HI` and `ST_RX_LO` repeat 16 times, with a sample taken at the end of each low phase. After the 16th sample the sequencer goes to `ST_DESELECT`, which drops select.
- `ST_TAIL_HI` and `ST_TAIL_LO` give one trailing pulse, then the sequencer returns to `ST_IDLE` with done.

Each state advances only when the pacing timer expires. The exception is `ST_IDLE`, which advances on start. The data-out pin passes through a two-flop synchronizer, so `HALF_CYC` must be at least 2.

Top module: `sprom_word_fetch`

## Requirements
- R1: Out of reset, `cs_o`, `sclk_o`, `mosi_o`, `busy_o` and `done_o` are 0 and `data_o` is 0.
- R2: A start in idle raises `cs_o` while `sclk_o` is low. Exactly one full `sclk_o` pulse follows, and then the read command bits 1, 1, 0 go out in that order, one per rising edge of `sclk_o`.
- R3: With `wide_i`=0, the address sent is `addr_i[5:0]` (6 bits). With `wide_i`=1, it is `addr_i[7:0]` (8 bits). Both are sent most significant bit first, immediately after the command.
- R4: Every level of the three outgoing pins lasts at least `HALF_CYC` system clocks, and each `sclk_o` high phase lasts exactly `HALF_CYC` clocks. `mosi_o` changes only while `sclk_o` is low.
- R5: `mosi_o` is 0 at every rising edge of `sclk_o` after the last address bit.
- R6: Exactly 16 `sclk_o` pulses follow the address while `cs_o` is high. The word is sampled after each full pulse, and the first sample is bit 15 of `data_o`. The memory's dummy 0 comes out on the last address edge and is never captured.
- R7: After the 16th bit, `cs_o` falls while `sclk_o` is low, and exactly one more `sclk_o` pulse follows. `done_o` is then high for one cycle, in the same cycle that `busy_o` returns to 0.
- R8: A start that arrives while `busy_o` is high is ignored. The current transfer keeps its address, and no second transfer follows it.
- R9: `data_o` changes only in a cycle where `done_o` is high. It keeps the last word through idle time and through the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to read a word |
| addr_i | input | 8 | Word address; only bits 5:0 are used when `wide_i` is 0 |
| wide_i | input | 1 | 1 selects an 8-bit address, 0 selects a 6-bit address |
| busy_o | output | 1 | High while a transfer is in progress |
| done_o | output | 1 | One-cycle pulse when `data_o` is updated |
| data_o | output | 16 | Last word read |
| cs_o | output | 1 | Memory chip select, active high |
| sclk_o | output | 1 | Memory serial clock |
| mosi_o | output | 1 | Serial data to the memory |
| miso_i | input | 1 | Serial data from the memory (asynchronous) |

## Verification
Some properties are checked by assertions on every cycle:

- Each pin level lasts at least `HALF_CYC` clocks.
- `mosi_o` holds while the clock is high.
- Select changes only while the clock is low.
- `done_o` is a single-cycle pulse that coincides with `busy_o` falling.
- `data_o` moves only with `done_o`.

Other behaviour only the scenarios can show, by running a memory model that decodes the pins:

- The order of the leading pulse, command and address bits.
- The 6-bit or 8-bit address length.
- The alignment of the dummy zero against the 16 samples.
- The single trailing pulse.
- The fact that a start during a transfer changes nothing.

// File: rtl/sprom_pkg.sv
package sprom_pkg;
    localparam int WORD_W     = 16;
    localparam int ADDR_MAX_W = 8;
    localparam int ADDR_MIN_W = 6;
    localparam int OP_W       = 3;
    localparam logic [OP_W-1:0] RD_OPCODE = 3'b110;
    localparam int TX_W       = OP_W + ADDR_MAX_W;
    localparam int TXC_W      = $clog2(TX_W);
    localparam int RXC_W      = $clog2(WORD_W);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SELECT,
        ST_LEAD_HI,
        ST_LEAD_LO,
        ST_TX_SET,
        ST_TX_HI,
        ST_TX_LO,
        ST_RX_PREP,
        ST_RX_HI,
        ST_RX_LO,
        ST_DESELECT,
        ST_TAIL_HI,
        ST_TAIL_LO
    } seq_state_t;
endpackage

// File: rtl/sprom_sync.sv
module sprom_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sprom_pacer.sv
module sprom_pacer #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= RELOAD;
        else if (!run_i)           cnt_q <= RELOAD;
        else if (cnt_q == '0)      cnt_q <= RELOAD;
        else                       cnt_q <= cnt_q - 1'b1;
    end

    assign tick_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/sprom_word_fetch.sv
module sprom_word_fetch
    import sprom_pkg::*;
#(
    parameter int HALF_CYC    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [ADDR_MAX_W-1:0] addr_i,
    input  logic                  wide_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic [WORD_W-1:0]     data_o,
    output logic                  cs_o,
    output logic                  sclk_o,
    output logic                  mosi_o,
    input  logic                  miso_i
);
    localparam logic [TXC_W-1:0] TXN_WIDE   = TXC_W'(TX_W - 1);
    localparam logic [TXC_W-1:0] TXN_NARROW = TXC_W'(OP_W + ADDR_MIN_W - 1);
    localparam int PAD_W = ADDR_MAX_W - ADDR_MIN_W;

    seq_state_t state_q, state_d;
    logic              tick;
    logic              miso_s;
    logic [TX_W-1:0]   tx_sh_q;
    logic [TXC_W-1:0]  tx_cnt_q;
    logic [WORD_W-1:0] rx_sh_q;
    logic [RXC_W-1:0]  rx_cnt_q;
    logic [WORD_W-1:0] data_q;
    logic              done_q;

    sprom_pacer #(.HALF_CYC(HALF_CYC)) u_pacer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state_q != ST_IDLE),
        .tick_o (tick)
    );

    sprom_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (miso_i),
        .q_o   (miso_s)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i) state_d = ST_SELECT;
            ST_SELECT:   if (tick) state_d = ST_LEAD_HI;
            ST_LEAD_HI:  if (tick) state_d = ST_LEAD_LO;
            ST_LEAD_LO:  if (tick) state_d = ST_TX_SET;
            ST_TX_SET:   if (tick) state_d = ST_TX_HI;
            ST_TX_HI:    if (tick) state_d = ST_TX_LO;
            ST_TX_LO:    if (tick) state_d = (tx_cnt_q == '0) ? ST_RX_PREP : ST_TX_SET;
            ST_RX_PREP:  if (tick) state_d = ST_RX_HI;
            ST_RX_HI:    if (tick) state_d = ST_RX_LO;
            ST_RX_LO:    if (tick) state_d = (rx_cnt_q == '0) ? ST_DESELECT : ST_RX_HI;
            ST_DESELECT: if (tick) state_d = ST_TAIL_HI;
            ST_TAIL_HI:  if (tick) state_d = ST_TAIL_LO;
            ST_TAIL_LO:  if (tick) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // pin decode
    always_comb begin
        cs_o   = 1'b0;
        sclk_o = 1'b0;
        mosi_o = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DESELECT, ST_TAIL_LO: ;
            ST_TAIL_HI:                       sclk_o = 1'b1;
            ST_SELECT, ST_LEAD_LO,
            ST_RX_PREP, ST_RX_LO:             cs_o = 1'b1;
            ST_LEAD_HI, ST_RX_HI: begin
                cs_o   = 1'b1;
                sclk_o = 1'b1;
            end
            ST_TX_SET, ST_TX_LO: begin
                cs_o   = 1'b1;
                mosi_o = tx_sh_q[TX_W-1];
            end
            ST_TX_HI: begin
                cs_o   = 1'b1;
                sclk_o = 1'b1;
                mosi_o = tx_sh_q[TX_W-1];
            end
            default: ;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh_q  <= '0;
            tx_cnt_q <= '0;
            rx_sh_q  <= '0;
            rx_cnt_q <= '0;
            data_q   <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (state_q == ST_IDLE && start_i) begin
                tx_sh_q  <= wide_i ? {RD_OPCODE, addr_i}
                                   : {RD_OPCODE, addr_i[ADDR_MIN_W-1:0], {PAD_W{1'b0}}};
                tx_cnt_q <= wide_i ? TXN_WIDE : TXN_NARROW;
                rx_cnt_q <= RXC_W'(WORD_W - 1);
            end
            if (state_q == ST_TX_LO && tick && tx_cnt_q != '0) begin
                tx_sh_q  <= {tx_sh_q[TX_W-2:0], 1'b0};
                tx_cnt_q <= tx_cnt_q - 1'b1;
            end
            if (state_q == ST_RX_LO && tick) begin
                rx_sh_q <= {rx_sh_q[WORD_W-2:0], miso_s};
                if (rx_cnt_q != '0) rx_cnt_q <= rx_cnt_q - 1'b1;
            end
            if (state_q == ST_TAIL_LO && tick) begin
                done_q <= 1'b1;
                data_q <= rx_sh_q;
            end
        end
    end

    assign busy_o = (state_q != ST_IDLE);
    assign done_o = done_q;
    assign data_o = data_q;
endmodule

// File: rtl/sprom_word_fetch_chk.sv
module sprom_word_fetch_chk #(
    parameter int HALF_CYC = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        busy_o,
    input logic        done_o,
    input logic [15:0] data_o,
    input logic        cs_o,
    input logic        sclk_o,
    input logic        mosi_o
);
    localparam int RW = $clog2(HALF_CYC + 1) + 1;
    localparam logic [RW-1:0] RUN_MAX = RW'(HALF_CYC);

    logic [2:0]    pins, pins_q;
    logic [RW-1:0] run_q;
    logic          busy_q;

    assign pins = {cs_o, sclk_o, mosi_o};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins_q <= '0;
            run_q  <= '0;
            busy_q <= 1'b0;
        end else begin
            pins_q <= pins;
            busy_q <= busy_o;
            if (pins != pins_q)      run_q <= RW'(1);
            else if (run_q < RUN_MAX) run_q <= run_q + 1'b1;
        end
    end

    assert_pin_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && pins != pins_q) |-> (run_q >= RUN_MAX));

    assert_mosi_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

    assert_select_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_o) |-> !sclk_o);

    assert_select_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_o) |-> !sclk_o);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(data_o));
endmodule

bind sprom_word_fetch sprom_word_fetch_chk #(.HALF_CYC(HALF_CYC)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy_o (busy_o),
    .done_o (done_o),
    .data_o (data_o),
    .cs_o   (cs_o),
    .sclk_o (sclk_o),
    .mosi_o (mosi_o)
);

// File: tb/test_sprom_word_fetch.sv
`timescale 1ns/1ps
module test_sprom_word_fetch;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  addr = '0;
    logic        wide = 1'b0;
    logic        busy, done, cs, sclk, mosi;
    logic [15:0] data;
    logic        miso = 1'b0;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    sprom_word_fetch #(.HALF_CYC(HALF)) i_sprom_word_fetch (
        .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr), .wide_i(wide),
        .busy_o(busy), .done_o(done), .data_o(data),
        .cs_o(cs), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso)
    );

    function automatic logic [15:0] mem_fn(input logic [7:0] a);
        return {a ^ 8'h3C, {a[6:0], a[7]} ^ 8'hA5};
    endfunction

    // memory model, observed at the falling system clock edge
    int          m_alen = 6;
    int          edge_n = 0;
    int          tail_n = 0;
    int          rd_mosi_hi = 0;
    int          hi_len = 0;
    int          hi_min = 0;
    int          hi_max = 0;
    logic [2:0]  op_rx = '0;
    logic [7:0]  ad_rx = '0;
    logic [15:0] cur_word = '0;
    logic        sclk_p = 1'b0;
    logic        cs_p = 1'b0;

    always @(negedge clk) begin
        if (cs && !cs_p) begin
            edge_n = 0; tail_n = 0; rd_mosi_hi = 0;
            op_rx = '0; ad_rx = '0;
            hi_min = 1000; hi_max = 0;
        end
        if (sclk) hi_len++;
        if (!sclk && sclk_p) begin
            if (hi_len < hi_min) hi_min = hi_len;
            if (hi_len > hi_max) hi_max = hi_len;
            hi_len = 0;
        end
        if (sclk && !sclk_p) begin
            if (cs) begin
                edge_n++;
                if (edge_n >= 2 && edge_n <= 4)
                    op_rx = {op_rx[1:0], mosi};
                else if (edge_n >= 5 && edge_n <= 4 + m_alen)
                    ad_rx = {ad_rx[6:0], mosi};
                else if (edge_n > 4 + m_alen && mosi)
                    rd_mosi_hi++;
                if (edge_n == 4 + m_alen) begin
                    cur_word = mem_fn(ad_rx);
                    miso <= 1'b0;
                end else if (edge_n > 4 + m_alen && edge_n <= 20 + m_alen) begin
                    miso <= cur_word[20 + m_alen - edge_n];
                end
            end else begin
                tail_n++;
            end
        end
        sclk_p = sclk;
        cs_p   = cs;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [7:0] a, input logic w);
        @(negedge clk);
        addr = a; wide = w; m_alen = w ? 8 : 6; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 5000 && !done; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(cs == 0 && sclk == 0 && mosi == 0, "R1", "pins idle", {cs, sclk, mosi}, 0);
        chk(busy == 0 && done == 0, "R1", "busy/done", {busy, done}, 0);
        chk(data == 0, "R1", "data", data, 0);
    endtask

    task automatic t_read(input logic [7:0] a, input logic w);
        logic [7:0] am;
        am = w ? a : {2'b00, a[5:0]};
        pulse_start(a, w);
        chk(busy == 1, "R2", "busy after start", busy, 1);
        wait_done();
        chk(done == 1, "R7", "done seen", done, 1);
        chk(busy == 0, "R7", "busy low with done", busy, 0);
        chk(data == mem_fn(am), "R6", "word", data, mem_fn(am));
        chk(op_rx == 3'b110, "R2", "opcode", op_rx, 3'b110);
        chk(ad_rx == am, "R3", "address", ad_rx, am);
        chk(edge_n == 20 + m_alen, "R6", "edges under select", edge_n, 20 + m_alen);
        chk(rd_mosi_hi == 0, "R5", "mosi high in read", rd_mosi_hi, 0);
        chk(tail_n == 1, "R7", "trailing pulses", tail_n, 1);
        chk(hi_min == HALF && hi_max == HALF, "R4", "clock high width", hi_max, HALF);
        @(negedge clk);
        chk(done == 0, "R7", "done one cycle", done, 0);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] a1;
        a1 = 8'h9E;
        pulse_start(a1, 1'b1);
        repeat (60) @(negedge clk);
        addr = 8'h11; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk(data == mem_fn(a1), "R8", "word of first request", data, mem_fn(a1));
        chk(ad_rx == a1, "R8", "address kept", ad_rx, a1);
        repeat (30) @(negedge clk);
        chk(busy == 0 && cs == 0, "R8", "no second transfer", {busy, cs}, 0);
    endtask

    task automatic t_hold();
        logic [15:0] prev;
        prev = data;
        repeat (40) @(negedge clk);
        chk(data == prev, "R9", "held in idle", data, prev);
        pulse_start(8'h05, 1'b0);
        repeat (150) @(negedge clk);
        chk(busy == 1 && data == prev, "R9", "held mid transfer", data, prev);
        wait_done();
        chk(data == mem_fn(8'h05), "R9", "updated at done", data, mem_fn(8'h05));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_read(8'h2A, 1'b0);
        t_read(8'h3F, 1'b0);
        t_read(8'h00, 1'b0);
        t_read(8'hC5, 1'b0);   // R3: upper bits dropped in 6-bit mode
        t_read(8'hFF, 1'b1);
        t_read(8'h81, 1'b1);
        t_read(8'h00, 1'b1);
        t_busy_ignore();
        t_hold();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule